// File: doc/BRIEF.md
# Multi-Mode 16-Bit Capture Timer

A 16-bit timer/counter that advances on a qualified tick from an external prescaler while its run bit is set. In capture mode it is a free-running up-counter. A falling edge on the external pin copies the live count into a shared capture/reload register and raises an external-event flag. In reload mode a 2-bit field picks one of four counting schemes: a plain up-count that reloads on overflow, a count that clears when it matches the reload value, and two dual-slope up/down schemes. In the plain scheme the direction can also be steered by the external pin.

An overflow flag and an external-event flag are combined into one interrupt request. An optional output pin toggles on every overflow. Software reaches the count, the capture/reload register, the control byte and the flags through a small word-wide register port. The read data is combinational on the address. Address map: 0 count, 1 capture/reload, 2 control, 3 flags.

Control byte bits: 0 run, 2:1 count scheme, 3 capture select, 4 pin enable, 5 direction steering, 6 output enable, 7 event counting.

Top module: `cap_timer16`

## Requirements
- R1: After reset the count, the capture/reload register, the control byte, both flags, the output pin and the interrupt request all read 0.
- R2: The count changes only on a cycle where control bit 0 (run) and the tick input are both 1, or where the bus writes address 0. A bus write to address 0 loads the write data at the next edge and takes priority over counting.
- R3: With control bit 3 set (capture mode), the count steps up by one per advance and wraps from 0xFFFF to 0. That wrap sets the overflow flag, which is flags bit 0.
- R4: The pin passes through two synchronizing flops, and a falling edge is detected between the second flop and a third history flop. In capture mode with control bit 4 set, a detected edge copies the count held in that cycle into address 1 and sets the external flag (flags bit 1). A capture overrides a bus write to address 1 in the same cycle.
- R5: In reload mode (bit 3 clear) with scheme 00 and no steering, an advance at 0xFFFF loads the reload value and sets the overflow flag.
- R6: In scheme 00 with bits 4 and 5 both set, a synchronized pin level of 1 counts up and a level of 0 counts down. Counting down, an advance with the count equal to the reload value loads 0xFFFF and sets the overflow flag.
- R7: In scheme 01 the count climbs from its value. An advance with the count equal to the reload value clears it to 0 and sets the overflow flag.
- R8: In schemes 10 and 11 the count rises to the active top, then steps down to 0, then turns back to 1. Only the bottom turnaround sets the overflow flag. While run is 0 the active top follows the reload register and the direction returns to up.
- R9: Scheme 10 takes a new top from the reload register only at the bottom turnaround. Scheme 11 takes it at both the top and the bottom turnarounds.
- R10: Writing flags with a 0 in a bit position clears that flag, and writing a 1 leaves it unchanged. An overflow or external event in the same cycle as a clear leaves the flag set.
- R11: The interrupt request is 1 exactly when at least one flag is 1.
- R12: With control bit 6 set and bit 7 clear, the output pin toggles on every overflow. Otherwise it holds its level.
- R13: In reload mode a detected falling edge with bit 4 set raises the external flag, except in scheme 00 with bit 5 set. It does not touch the capture/reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick qualifying a count step |
| ext_pin_i | input | 1 | Asynchronous external capture/steering pin, idle high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | W | Register write data |
| bus_rdata_o | output | W | Register read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| out_pin_o | output | 1 | Overflow toggle output |

## Verification
The assertions assume that the pin idles high through reset, since the synchronizer resets to 1. They also assume that W is at least 8, so the control byte fits in one bus word. The stimulus holds the pin high until a scenario wants edges. It keeps each pin level for several cycles, so every edge survives synchronization. It issues at most one bus write per cycle. It also loads dual-slope reload values of 1 or more, so the turnarounds stay well-formed. Ticks are drawn at several densities, so advance cycles and stall cycles interleave with bus writes and pin edges.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_CLR  = 2'b01,
        CM_DS1  = 2'b10,
        CM_DS2  = 2'b11
    } cmode_e;

    // control byte, MSB first: evt, oe, dcen, pin_en, cap, cmode, run
    typedef struct packed {
        logic   evt;
        logic   oe;
        logic   steer;
        logic   pin_en;
        logic   cap;
        cmode_e cmode;
        logic   run;
    } ctrl_t;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_RLD  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

endpackage

// File: rtl/cap_timer_sync.sv
module cap_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic fall_o
);
    // sh[0..STAGES-1] synchronizer, sh[STAGES] history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/cap_timer_count.sv
module cap_timer_count
    import cap_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic         run_i,
    input  logic         cap_i,
    input  cmode_e       cmode_i,
    input  logic         steer_i,
    input  logic         up_lvl_i,
    input  logic [W-1:0] rld_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] top;
        logic         down;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = 1'b0;
        if (wr_i) begin
            st_d.cnt = wdata_i;
        end else if (adv_i) begin
            if (cap_i) begin
                st_d.cnt = st_q.cnt + ONE;
                ovf_o    = (st_q.cnt == MAXV);
            end else begin
                case (cmode_i)
                    CM_UP: begin
                        if (steer_i && !up_lvl_i) begin
                            if (st_q.cnt == rld_i) begin
                                st_d.cnt = MAXV;
                                ovf_o    = 1'b1;
                            end else begin
                                st_d.cnt = st_q.cnt - ONE;
                            end
                        end else if (st_q.cnt == MAXV) begin
                            st_d.cnt = rld_i;
                            ovf_o    = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end
                    CM_CLR: begin
                        if (st_q.cnt == rld_i) begin
                            st_d.cnt = '0;
                            ovf_o    = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end
                    default: begin
                        if (!st_q.down) begin
                            if (st_q.cnt >= st_q.top) begin
                                st_d.down = 1'b1;
                                st_d.cnt  = (st_q.cnt == '0) ? '0 : st_q.cnt - ONE;
                                if (cmode_i == CM_DS2) st_d.top = rld_i;
                            end else begin
                                st_d.cnt = st_q.cnt + ONE;
                            end
                        end else if (st_q.cnt == '0) begin
                            st_d.down = 1'b0;
                            st_d.cnt  = ONE;
                            st_d.top  = rld_i;
                            ovf_o     = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                        end
                    end
                endcase
            end
        end
        if (!run_i) begin
            st_d.top  = rld_i;
            st_d.down = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !wr_i) |=> $stable(cnt_o)); // R2

    AST_OVF_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (adv_i && !wr_i)); // R2

    AST_CAP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wr_i && cap_i && cnt_o == MAXV) |=> (cnt_o == '0)); // R3

    AST_DS_BOTTOM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wr_i && !cap_i && cmode_i[1] && st_q.down && cnt_o == '0)
            |=> (cnt_o == ONE && !st_q.down)); // R8

endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
    import cap_timer_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         ext_pin_i,
    input  logic         bus_wr_i,
    input  logic [1:0]   bus_addr_i,
    input  logic [W-1:0] bus_wdata_i,
    output logic [W-1:0] bus_rdata_o,
    output logic         irq_o,
    output logic         out_pin_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] rld;
        logic         ovf_flag;
        logic         ext_flag;
        logic         opin;
    } top_st_t;

    top_st_t st_d, st_q;

    logic         pin_lvl, pin_fall;
    logic [W-1:0] cnt;
    logic         ovf;
    logic         adv, cap_ev, ext_ev;
    logic         wr_cnt, wr_rld, wr_ctrl, wr_flag;

    cap_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .lvl_o  (pin_lvl),
        .fall_o (pin_fall)
    );

    cap_timer_count #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .run_i    (st_q.ctrl.run),
        .cap_i    (st_q.ctrl.cap),
        .cmode_i  (st_q.ctrl.cmode),
        .steer_i  (st_q.ctrl.steer & st_q.ctrl.pin_en),
        .up_lvl_i (pin_lvl),
        .rld_i    (st_q.rld),
        .wr_i     (wr_cnt),
        .wdata_i  (bus_wdata_i),
        .cnt_o    (cnt),
        .ovf_o    (ovf)
    );

    always_comb begin
        wr_cnt  = bus_wr_i && (bus_addr_i == ADDR_CNT);
        wr_rld  = bus_wr_i && (bus_addr_i == ADDR_RLD);
        wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_CTRL);
        wr_flag = bus_wr_i && (bus_addr_i == ADDR_FLAG);
        adv     = st_q.ctrl.run & tick_i;
        cap_ev  = st_q.ctrl.cap & st_q.ctrl.pin_en & pin_fall;
        ext_ev  = st_q.ctrl.pin_en & pin_fall &
                  (st_q.ctrl.cap | !(st_q.ctrl.cmode == CM_UP && st_q.ctrl.steer));

        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
        if (cap_ev)      st_d.rld = cnt;
        else if (wr_rld) st_d.rld = bus_wdata_i;
        if (wr_flag && !bus_wdata_i[0]) st_d.ovf_flag = 1'b0;
        if (wr_flag && !bus_wdata_i[1]) st_d.ext_flag = 1'b0;
        if (ovf)    st_d.ovf_flag = 1'b1;
        if (ext_ev) st_d.ext_flag = 1'b1;
        if (ovf && st_q.ctrl.oe && !st_q.ctrl.evt) st_d.opin = ~st_q.opin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr_i)
            ADDR_CNT:  bus_rdata_o = cnt;
            ADDR_RLD:  bus_rdata_o = st_q.rld;
            ADDR_CTRL: bus_rdata_o = {{(W-CTRL_W){1'b0}}, st_q.ctrl};
            default:   bus_rdata_o = {{(W-2){1'b0}}, st_q.ext_flag, st_q.ovf_flag};
        endcase
    end

    assign irq_o     = st_q.ovf_flag | st_q.ext_flag;
    assign out_pin_o = st_q.opin;

    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (st_q.rld == $past(cnt))); // R4

    AST_OVF_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> irq_o); // R10

    AST_PIN_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && st_q.ctrl.oe && !st_q.ctrl.evt) |=> (out_pin_o != $past(out_pin_o))); // R12

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(out_pin_o)); // R12

endmodule

// File: tb/sim_cap_timer16.sv
`timescale 1ns/1ps
module sim_cap_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pin = 1'b1;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq, opin;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string tag = "R1";
    int    rd_ptr = 0;

    always #2 clk = ~clk;

    cap_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_pin_i(pin),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .out_pin_o(opin)
    );

    // behavioural reference state
    logic [15:0] m_cnt, m_top, m_rld;
    logic        m_down, m_tf, m_exf, m_op;
    logic [7:0]  m_ctrl;
    logic        m_s1, m_s2, m_sp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_top = 0; m_rld = 0; m_down = 0;
            m_tf = 0; m_exf = 0; m_op = 0; m_ctrl = 0;
            m_s1 = 1; m_s2 = 1; m_sp = 1;
        end else begin : step
            logic        adv, fall, ovf, down_req;
            logic [1:0]  md;
            logic [15:0] nc, nt, nr;
            logic        nd;
            adv  = m_ctrl[0] && tick;
            fall = m_sp && !m_s2;
            md   = m_ctrl[2:1];
            ovf  = 0; nc = m_cnt; nt = m_top; nd = m_down;
            down_req = m_ctrl[5] && m_ctrl[4] && !m_s2;
            if (wr && addr == 2'd0) nc = wdata;
            else if (adv) begin
                if (m_ctrl[3]) begin
                    ovf = (m_cnt == 16'hFFFF); nc = m_cnt + 16'd1;
                end else if (md == 2'd0) begin
                    if (down_req) begin
                        if (m_cnt == m_rld) begin nc = 16'hFFFF; ovf = 1; end
                        else nc = m_cnt - 16'd1;
                    end else if (m_cnt == 16'hFFFF) begin nc = m_rld; ovf = 1; end
                    else nc = m_cnt + 16'd1;
                end else if (md == 2'd1) begin
                    if (m_cnt == m_rld) begin nc = 0; ovf = 1; end
                    else nc = m_cnt + 16'd1;
                end else if (!m_down) begin
                    if (m_cnt >= m_top) begin
                        nd = 1; nc = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
                        if (md == 2'd3) nt = m_rld;
                    end else nc = m_cnt + 16'd1;
                end else if (m_cnt == 0) begin
                    nd = 0; nc = 16'd1; nt = m_rld; ovf = 1;
                end else nc = m_cnt - 16'd1;
            end
            if (!m_ctrl[0]) begin nt = m_rld; nd = 0; end
            nr = m_rld;
            if (m_ctrl[3] && m_ctrl[4] && fall) nr = m_cnt;
            else if (wr && addr == 2'd1) nr = wdata;
            if (wr && addr == 2'd3 && !wdata[0]) m_tf = 0;
            if (wr && addr == 2'd3 && !wdata[1]) m_exf = 0;
            if (ovf) m_tf = 1;
            if (m_ctrl[4] && fall && (m_ctrl[3] || !(md == 2'd0 && m_ctrl[5]))) m_exf = 1;
            if (ovf && m_ctrl[6] && !m_ctrl[7]) m_op = !m_op;
            if (wr && addr == 2'd2) m_ctrl = wdata[7:0];
            m_cnt = nc; m_top = nt; m_down = nd; m_rld = nr;
            m_sp = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin : cmp
            logic [15:0] exp_rd;
            case (addr)
                2'd0:    exp_rd = m_cnt;
                2'd1:    exp_rd = m_rld;
                2'd2:    exp_rd = {8'd0, m_ctrl};
                default: exp_rd = {14'd0, m_exf, m_tf};
            endcase
            n_chk++;
            if (rdata !== exp_rd || irq !== (m_tf | m_exf) || opin !== m_op) begin
                n_err++;
                $display("FAIL %s addr=%0d actual rd=%h irq=%b pin=%b expected rd=%h irq=%b pin=%b",
                         tag, addr, rdata, irq, opin, exp_rd, m_tf | m_exf, m_op);
            end
        end
    end

    task automatic idle(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr = 0; addr = 2'(rd_ptr); rd_ptr++;
            tick = ($urandom % 100) < pct;
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr = 1; addr = a; wdata = d; tick = 1;
    endtask

    task automatic pulses(input int k, input int lo, input int hi, input int pct);
        for (int i = 0; i < k; i++) begin
            pin = 0; idle(lo, pct);
            pin = 1; idle(hi, pct);
        end
    endtask

    initial begin : wd
        #800000;
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tag = "R1";  idle(4, 0);
        tag = "R2";  wreg(0, 16'h0100); wreg(2, 16'h0008); idle(12, 100);
        wreg(2, 16'h0009); idle(30, 50);
        tag = "R3";  wreg(0, 16'hFFF0); idle(40, 100);
        tag = "R4";  wreg(2, 16'h0019); pulses(5, 5, 7, 70);
        wreg(3, 16'h0000); pin = 0; wreg(1, 16'h1234); idle(3, 100); wreg(1, 16'h5678); pin = 1; idle(6, 100);
        tag = "R10"; wreg(0, 16'hFFFC);
        for (int i = 0; i < 8; i++) wreg(3, 16'h0000);
        wreg(3, 16'h0003); idle(4, 0); wreg(3, 16'h0002); idle(3, 0);
        tag = "R11"; wreg(3, 16'h0000); idle(4, 0);
        tag = "R5";  wreg(2, 16'h0001); wreg(1, 16'hFFF8); wreg(0, 16'hFFF0); idle(40, 100);
        tag = "R6";  wreg(1, 16'h0010); wreg(0, 16'h0014); pin = 0; wreg(2, 16'h0031);
        idle(30, 100); pin = 1; idle(20, 100); pulses(2, 6, 6, 100);
        tag = "R13"; wreg(3, 16'h0000); wreg(2, 16'h0011); pulses(2, 5, 5, 60);
        wreg(3, 16'h0000); wreg(2, 16'h0013); pulses(2, 5, 5, 60);
        tag = "R7";  wreg(3, 16'h0000); wreg(2, 16'h0003); wreg(1, 16'h0005); wreg(0, 16'h0000); idle(40, 80);
        tag = "R8";  wreg(2, 16'h0004); wreg(1, 16'h0006); wreg(0, 16'h0000); idle(3, 100);
        wreg(2, 16'h0005); idle(40, 100);
        tag = "R9";  wreg(1, 16'h0003); idle(40, 100);
        wreg(2, 16'h0006); wreg(1, 16'h0005); wreg(0, 16'h0000); wreg(2, 16'h0007); idle(8, 100);
        wreg(1, 16'h0009); idle(60, 100); wreg(1, 16'h0002); idle(30, 70);
        tag = "R12"; wreg(2, 16'h0049); wreg(0, 16'hFFF8); idle(30, 100);
        wreg(2, 16'h00C9); wreg(0, 16'hFFF8); idle(30, 100);
        wreg(2, 16'h0041); wreg(1, 16'hFFFC); wreg(0, 16'hFFF8); idle(30, 100);
        idle(2, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule